// File: doc/BRIEF.md
# PCM Transmit Serial Port with Frame Signaling

This block puts one parallel PCM word per frame onto a serial line of a time-division voice highway. The word arrives already companded. The block sends it most significant bit first. It sends one bit on each detected rising edge of the transmit data clock. A system clock, much faster than the highway clocks, samples the highway clock and sync inputs through synchronizer chains, and all logic runs on that system clock.

The block has two timing modes. In fixed-rate mode the master clock is also the bit clock, and a frame-sync pulse starts the slot. The length of that pulse gives the frame type: one bit clock means a normal frame, two bit clocks mean a signaling frame. In a signaling frame the last bit sent comes from a separate signaling input. In variable-rate mode a separate data clock is used, and the sync input acts as a time-slot enable. The enable must stay high for the whole slot.

In fixed-rate mode an active-low strobe marks the slot so that it can enable an external 3-state buffer. The serial output itself is modelled as a data bit plus an output enable. The output is released when no slot is active, in standby, and when the power-down input is low. Standby starts after the sync input has stayed low for a parameterized number of system cycles.

Top module: `pcm_tx_port`

## Requirements
- R1: A slot sends exactly WORD_W bits (default 8), MSB first. The first bit is launched at the slot's starting bit-clock rise, and each following rise launches the next bit. The rise after the last bit drops `sdo_oe`. While `sdo_oe` is high, `sdo` carries the current bit.
- R2: A level change on `mclk`, `dclk`, `fsync` or `pdn_n` first sampled at system clock edge N can first affect the outputs right after edge N+2. The serial data changes only after a detected bit-clock rise.
- R3: With `mode_var`=0 the bit clock is `mclk`. A slot starts at a bit-clock rise where the synchronized `fsync` is high and was low at the previous bit-clock rise.
- R4: In fixed-rate mode, if `fsync` is still high at the second rise of the slot, the frame is a signaling frame. Its last bit is the level of `sig_bit` at the rise that launches it, not the word's LSB. Otherwise the word's LSB is sent.
- R5: With `mode_var`=1 the bit clock is `dclk`, and no signaling is done: the word's LSB is always sent. If `fsync` is low at any bit-clock rise during a slot, `sdo_oe` drops at that rise and the rest of the slot is abandoned.
- R6: In fixed-rate mode, `slot_strobe_n` is low exactly while `sdo_oe` is high. In variable-rate mode it stays high.
- R7: After SYNC_LOSS_CYCLES consecutive system cycles with the synchronized `fsync` low, `standby` goes to 1. It clears when `fsync` is seen high. While `standby` is 1, `sdo_oe` is 0 and no slot starts.
- R8: While the synchronized `pdn_n` is low, `sdo_oe` is 0 and `slot_strobe_n` is 1, and any slot in progress is abandoned.
- R9: `pcm_word` is captured at the starting rise. Changing it later in the slot does not alter the bits sent.
- R10: After reset, `sdo_oe`=0, `slot_strobe_n`=1, `standby`=0 and `sdo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_var | input | 1 | 0 selects fixed-rate mode, 1 selects variable-rate mode |
| mclk | input | 1 | Master clock, used as the bit clock in fixed-rate mode |
| dclk | input | 1 | Data clock, used as the bit clock in variable-rate mode |
| fsync | input | 1 | Frame sync (fixed-rate mode) or time-slot enable (variable-rate mode) |
| pdn_n | input | 1 | Power-down control: low makes the block inactive |
| sig_bit | input | 1 | Signaling bit that replaces the LSB in signaling frames |
| pcm_word | input | WORD_W | Parallel PCM word to send |
| sdo | output | 1 | Serial PCM data |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| slot_strobe_n | output | 1 | Active-low time-slot strobe for an external 3-state buffer |
| standby | output | 1 | High after a long absence of sync |

## Verification
A wrong slot counter shows up at the bit-clock rise where the slot should end: `sdo_oe` stays high too long or drops too early. A wrong frame-type flag only shows in the last bit, about seven bit periods after the sync pulse that set it. That last bit is therefore checked with `sig_bit` set to the opposite of the word's LSB. Synchronizer or edge-detect faults shift every output by whole system cycles, and are caught by a model of the block compared on every clock and by a probe of the exact start latency. Watchdog faults show at the single cycle where `standby` should rise.

// File: rtl/pcm_tx_pkg.sv
`timescale 1ns/1ps
package pcm_tx_pkg;
   // bit positions inside the synchronized input vector
   localparam int SIN_MCLK = 0;
   localparam int SIN_DCLK = 1;
   localparam int SIN_FS   = 2;
   localparam int SIN_PDN  = 3;
   localparam int SIN_NUM  = 4;

   function automatic int cnt_width(input longint limit);
      int w;
      w = 1;
      while ((64'd1 << w) <= limit) w++;
      return w;
   endfunction
endpackage

// File: rtl/pcm_tx_sync.sv
`timescale 1ns/1ps
module pcm_tx_sync #(
   parameter int N_IN   = 4,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] async_in,
   output logic [N_IN-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pcm_tx_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < N_IN; g++) begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[g]};
         end
         assign sync_out[g] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pcm_tx_watchdog.sv
`timescale 1ns/1ps
module pcm_tx_watchdog #(
   parameter longint SYNC_LOSS_CYCLES = 60_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_s,
   output logic standby
);
   import pcm_tx_pkg::*;
   localparam int CW = cnt_width(SYNC_LOSS_CYCLES);
   localparam logic [CW-1:0] TERM = CW'(SYNC_LOSS_CYCLES - 1);

   logic [CW-1:0] low_cnt;

   generate
      if (SYNC_LOSS_CYCLES < 2) begin : g_bad
         $error("pcm_tx_watchdog: SYNC_LOSS_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         standby <= 1'b0;
      end else if (fs_s) begin
         low_cnt <= '0;
         standby <= 1'b0;
      end else if (low_cnt == TERM) begin
         standby <= 1'b1;
      end else begin
         low_cnt <= low_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pcm_tx_framer.sv
`timescale 1ns/1ps
module pcm_tx_framer #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_var,
   input  logic              bclk_s,
   input  logic              fs_s,
   input  logic              pdn_s,
   input  logic              standby,
   input  logic              sig_bit,
   input  logic [WORD_W-1:0] pcm_word,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              slot_strobe_n,
   output logic              bit_rise
);
   localparam int IDX_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

   logic              bclk_prev;
   logic              fs_last;
   logic [WORD_W-1:0] shreg;
   logic [IDX_W-1:0]  idx, idx_next;
   logic              sig_q, sig_next;

   generate
      if (WORD_W < 2) begin : g_bad
         $error("pcm_tx_framer: WORD_W must be at least 2");
      end
   endgenerate

   assign bit_rise = bclk_s & ~bclk_prev;

   always_comb begin
      idx_next = idx + 1'b1;
      sig_next = (idx == '0) ? (fs_s & ~mode_var) : sig_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_prev <= 1'b0;
         fs_last   <= 1'b0;
      end else begin
         bclk_prev <= bclk_s;
         if (bit_rise) fs_last <= fs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo           <= 1'b0;
         sdo_oe        <= 1'b0;
         slot_strobe_n <= 1'b1;
         shreg         <= '0;
         idx           <= '0;
         sig_q         <= 1'b0;
      end else if (!pdn_s || standby) begin
         sdo_oe        <= 1'b0;
         slot_strobe_n <= 1'b1;
      end else if (bit_rise) begin
         if (!sdo_oe) begin
            if (fs_s && !fs_last) begin
               sdo_oe        <= 1'b1;
               slot_strobe_n <= mode_var;
               shreg         <= pcm_word;
               sdo           <= pcm_word[WORD_W-1];
               idx           <= '0;
               sig_q         <= 1'b0;
            end
         end else if ((mode_var && !fs_s) || idx == LAST) begin
            sdo_oe        <= 1'b0;
            slot_strobe_n <= 1'b1;
         end else begin
            idx   <= idx_next;
            sig_q <= sig_next;
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            sdo   <= (idx_next == LAST && sig_next) ? sig_bit : shreg[WORD_W-2];
         end
      end
   end
endmodule

// File: rtl/pcm_tx_port.sv
`timescale 1ns/1ps
module pcm_tx_port #(
   parameter int     WORD_W           = 8,
   parameter int     SYNC_STAGES      = 2,
   parameter longint SYNC_LOSS_CYCLES = 60_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_var,
   input  logic              mclk,
   input  logic              dclk,
   input  logic              fsync,
   input  logic              pdn_n,
   input  logic              sig_bit,
   input  logic [WORD_W-1:0] pcm_word,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              slot_strobe_n,
   output logic              standby
);
   import pcm_tx_pkg::*;

   logic [SIN_NUM-1:0] raw_in, syn_in;
   logic bclk_sel, fs_sync, pdn_sync, bit_rise;

   always_comb begin
      raw_in           = '0;
      raw_in[SIN_MCLK] = mclk;
      raw_in[SIN_DCLK] = dclk;
      raw_in[SIN_FS]   = fsync;
      raw_in[SIN_PDN]  = pdn_n;
   end

   pcm_tx_sync #(.N_IN(SIN_NUM), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(syn_in)
   );

   assign bclk_sel = mode_var ? syn_in[SIN_DCLK] : syn_in[SIN_MCLK];
   assign fs_sync  = syn_in[SIN_FS];
   assign pdn_sync = syn_in[SIN_PDN];

   pcm_tx_watchdog #(.SYNC_LOSS_CYCLES(SYNC_LOSS_CYCLES)) wdog_i (
      .clk(clk), .rst_n(rst_n), .fs_s(fs_sync), .standby(standby)
   );

   pcm_tx_framer #(.WORD_W(WORD_W)) framer_i (
      .clk(clk), .rst_n(rst_n), .mode_var(mode_var), .bclk_s(bclk_sel),
      .fs_s(fs_sync), .pdn_s(pdn_sync), .standby(standby), .sig_bit(sig_bit),
      .pcm_word(pcm_word), .sdo(sdo), .sdo_oe(sdo_oe),
      .slot_strobe_n(slot_strobe_n), .bit_rise(bit_rise)
   );
endmodule

// File: rtl/pcm_tx_port_chk.sv
`timescale 1ns/1ps
module pcm_tx_port_chk #(
   parameter int WORD_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic mode_var,
   input logic sdo,
   input logic sdo_oe,
   input logic slot_strobe_n,
   input logic standby,
   input logic bit_rise,
   input logic fs_sync,
   input logic pdn_sync
);
   // rises counted since the slot opened
   logic [7:0] rise_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rise_cnt <= '0;
      else if (!sdo_oe)  rise_cnt <= '0;
      else if (bit_rise) rise_cnt <= rise_cnt + 1'b1;
   end

   a_r1_slot_length: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (rise_cnt < 8'(WORD_W)));

   a_r2_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && !$past(bit_rise)) |-> $stable(sdo));

   a_r5_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_var && $past(bit_rise) && !$past(fs_sync)) |-> !sdo_oe);

   a_r6_strobe_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_strobe_n |-> (sdo_oe && !mode_var));

   a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !sdo_oe);

   a_r8_powerdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_sync |=> !sdo_oe);
endmodule

bind pcm_tx_port pcm_tx_port_chk #(.WORD_W(WORD_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .mode_var(mode_var), .sdo(sdo), .sdo_oe(sdo_oe),
   .slot_strobe_n(slot_strobe_n), .standby(standby), .bit_rise(bit_rise),
   .fs_sync(fs_sync), .pdn_sync(pdn_sync)
);

// File: tb/pcm_tx_port_tb_top.sv
`timescale 1ns/1ps
module pcm_tx_port_tb_top;
   localparam int W    = 8;
   localparam int LIM  = 300;
   localparam int HALF = 8;   // system cycles per bit-clock phase

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_var = 1'b0, mclk = 1'b0, dclk = 1'b0, fsync = 1'b0, pdn_n = 1'b1, sig_bit = 1'b0;
   logic [W-1:0] pcm_word = '0;
   logic sdo, sdo_oe, slot_strobe_n, standby;

   int checks = 0, errors = 0;
   string cur_req = "R10";
   bit done = 0;

   always #2.5 clk = ~clk;

   pcm_tx_port #(.WORD_W(W), .SYNC_STAGES(2), .SYNC_LOSS_CYCLES(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_var(mode_var), .mclk(mclk), .dclk(dclk),
      .fsync(fsync), .pdn_n(pdn_n), .sig_bit(sig_bit), .pcm_word(pcm_word),
      .sdo(sdo), .sdo_oe(sdo_oe), .slot_strobe_n(slot_strobe_n), .standby(standby)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit h_mc[3], h_dc[3], h_fs[3], h_pd[3];
   bit m_oe, m_stb, m_sdo, m_sb, m_fslast, m_sig;
   int m_idx, m_cnt;
   logic [W-1:0] m_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (h_mc[i]) begin h_mc[i] = 0; h_dc[i] = 0; h_fs[i] = 0; h_pd[i] = 0; end
         m_oe = 0; m_stb = 1; m_sdo = 0; m_sb = 0; m_fslast = 0; m_sig = 0;
         m_idx = 0; m_cnt = 0; m_word = '0;
      end else begin
         bit fs, pd, cb, pb, rise, old_sb;
         fs = h_fs[1]; pd = h_pd[1];
         cb = mode_var ? h_dc[1] : h_mc[1];
         pb = mode_var ? h_dc[2] : h_mc[2];
         rise = cb && !pb;
         old_sb = m_sb;
         if (fs) begin m_cnt = 0; m_sb = 0; end
         else if (m_cnt == LIM - 1) m_sb = 1;
         else m_cnt++;
         if (!pd || old_sb) begin
            m_oe = 0; m_stb = 1;
         end else if (rise) begin
            if (!m_oe) begin
               if (fs && !m_fslast) begin
                  m_oe = 1; m_stb = mode_var; m_word = pcm_word; m_idx = 0; m_sig = 0;
                  m_sdo = pcm_word[W-1];
               end
            end else if ((mode_var && !fs) || m_idx == W - 1) begin
               m_oe = 0; m_stb = 1;
            end else begin
               if (m_idx == 0) m_sig = fs && !mode_var;
               m_idx++;
               m_sdo = (m_idx == W - 1 && m_sig) ? sig_bit : m_word[W-1-m_idx];
            end
         end
         if (rise) m_fslast = fs;
         for (int i = 2; i > 0; i--) begin
            h_mc[i] = h_mc[i-1]; h_dc[i] = h_dc[i-1]; h_fs[i] = h_fs[i-1]; h_pd[i] = h_pd[i-1];
         end
         h_mc[0] = mclk; h_dc[0] = dclk; h_fs[0] = fsync; h_pd[0] = pdn_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sdo_oe == m_oe, cur_req, "model sdo_oe", sdo_oe, m_oe);
         chk(slot_strobe_n == m_stb, cur_req, "model slot_strobe_n", slot_strobe_n, m_stb);
         chk(standby == m_sb, cur_req, "model standby", standby, m_sb);
         if (m_oe) chk(sdo == m_sdo, cur_req, "model sdo", sdo, m_sdo);
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_bclk(input bit v, input bit vm);
      if (vm) dclk = v; else mclk = v;
   endtask

   // One slot: fsync held for 'hold' rises, 10 rises in total.
   task automatic frame(input bit vm, input logic [W-1:0] word, input bit sigb,
                        input int hold, input int chg_at, input int pd_at,
                        input bit probe, input string req);
      logic [W-1:0] exp;
      int valid;
      cur_req = req;
      mode_var = vm; pcm_word = word; sig_bit = sigb;
      exp = (!vm && hold >= 2) ? {word[W-1:1], sigb} : word;
      valid = W;
      if (vm && hold < W) valid = hold;
      if (pd_at >= 0) valid = pd_at + 1;
      fsync = 1'b1;
      wait_n(4);
      for (int k = 0; k < 10; k++) begin
         set_bclk(1'b1, vm);
         if (probe && k == 0) begin
            wait_n(2);
            chk(sdo_oe == 1'b0, "R2", "oe two edges after rise", sdo_oe, 0);
            wait_n(1);
            chk(sdo_oe == 1'b1, "R2", "oe three edges after rise", sdo_oe, 1);
            wait_n(HALF - 3);
         end else wait_n(HALF);
         if (k < valid) begin
            chk(sdo_oe == 1'b1, req, "slot active", sdo_oe, 1);
            chk(sdo == exp[W-1-k], req, $sformatf("bit %0d", k), sdo, exp[W-1-k]);
            chk(slot_strobe_n == vm, "R6", "strobe level in slot", slot_strobe_n, vm);
         end else begin
            chk(sdo_oe == 1'b0, req, $sformatf("released at rise %0d", k), sdo_oe, 0);
            chk(slot_strobe_n == 1'b1, "R6", "strobe idle", slot_strobe_n, 1);
         end
         set_bclk(1'b0, vm);
         wait_n(HALF / 2);
         if (k == hold - 1) fsync = 1'b0;
         if (k == chg_at) pcm_word = ~word;
         if (k == pd_at) pdn_n = 1'b0;
         wait_n(HALF / 2);
      end
      if (fsync) begin
         fsync = 1'b0;
         wait_n(4);
         set_bclk(1'b1, vm); wait_n(HALF);
         set_bclk(1'b0, vm); wait_n(HALF);
      end
      pdn_n = 1'b1;
      wait_n(6);
   endtask

   initial begin
      wait_n(3);
      chk(sdo_oe == 1'b0, "R10", "oe in reset", sdo_oe, 0);
      rst_n = 1'b1;
      wait_n(2);
      chk(sdo_oe == 1'b0, "R10", "oe after reset", sdo_oe, 0);
      chk(slot_strobe_n == 1'b1, "R10", "strobe after reset", slot_strobe_n, 1);
      chk(standby == 1'b0, "R10", "standby after reset", standby, 0);
      chk(sdo == 1'b0, "R10", "sdo after reset", sdo, 0);
      wait_n(10);

      frame(0, 8'hA5, 1'b1, 1, -1, -1, 1, "R3");     // normal frame, LSB from word
      frame(0, 8'h3C, 1'b1, 2, -1, -1, 0, "R4");     // signaling, LSB forced to 1
      frame(0, 8'h81, 1'b0, 2, -1, -1, 0, "R4");     // signaling, LSB forced to 0
      frame(0, 8'h5A, 1'b1, 1, 3, -1, 0, "R9");      // word changes mid-slot
      frame(0, 8'hF0, 1'b0, 1, -1, -1, 0, "R1");
      frame(1, 8'hC3, 1'b0, 12, -1, -1, 0, "R5");    // long enable, no signaling
      frame(1, 8'h96, 1'b1, 8, -1, -1, 0, "R5");
      frame(1, 8'h7E, 1'b0, 4, -1, -1, 0, "R5");     // enable drops mid-slot
      frame(0, 8'hE7, 1'b0, 1, -1, 3, 0, "R8");      // power-down mid-slot

      cur_req = "R7";
      mode_var = 1'b0;
      wait_n(LIM + 40);
      chk(standby == 1'b1, "R7", "standby after sync loss", standby, 1);
      chk(sdo_oe == 1'b0, "R7", "oe in standby", sdo_oe, 0);
      frame(0, 8'h42, 1'b1, 2, -1, -1, 0, "R7");     // sync returns, slot works
      chk(standby == 1'b0, "R7", "standby cleared", standby, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule